// File: doc/BRIEF.md
# Hysteretic Stop/Go Backpressure Link

This block models one point-to-point link between the output port of a sending router and the input port of a receiving router. Packets cross a data path that is pipelined over a fixed number of cycles. At the far end they land in a receive FIFO. A single backpressure bit runs the other way on its own wire, through the same number of pipeline cycles. The sender launches a packet only while the bit it currently observes says Go.

The receiver derives the bit from a two-state machine, `FC_GO` and `FC_STOP`. There are two transitions. **GO→STOP** is taken when the FIFO occupancy after the current edge reaches the upper threshold. **STOP→GO** is taken when that occupancy falls to the lower threshold. Between the two thresholds the state holds, which gives the bit its hysteresis.

The FIFO drains only while the consumer raises `drain_en`, and the consumer may hold it low for any length of time. The upper threshold is placed at least twice the link delay below the FIFO depth. That headroom absorbs every packet already on the wire, plus those launched before the Stop bit reaches the sender.

Top module: `lfc_link`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `rx_stop` is 0, `src_ready` is 1, `occupancy` is 0, `dst_valid` is 0 and `overflow_err` is 0.
- R2: A packet is taken from the source only on an edge where both `src_valid` and `src_ready` are 1. A packet offered while `src_ready` is 0 never reaches the FIFO.
- R3: A packet taken at edge k enters the FIFO at edge k+LINK_DELAY. `occupancy` reflects it from that edge on.
- R4: `src_ready` equals the inverse of `rx_stop` as it stood LINK_DELAY edges earlier. After reset the delayed value reads Go.
- R5: Transition GO→STOP: `rx_stop` (1 = Stop) becomes 1 at the edge where `occupancy` reaches STOP_TH or more. It is 1 whenever `occupancy` ≥ STOP_TH.
- R6: Transition STOP→GO: `rx_stop` returns to 0 at the edge where `occupancy` falls to GO_TH or lower. Between GO_TH and STOP_TH it keeps its value.
- R7: Packets leave the FIFO in arrival order. `dst_data` shows the oldest stored packet.
- R8: While `drain_en` is 0 no packet is removed, so `occupancy` never decreases across that edge.
- R9: With STOP_TH ≤ DEPTH − 2·LINK_DELAY the FIFO never overflows, even at full input rate with no draining. `overflow_err` is a sticky flag set by an arrival into a full FIFO with no removal on the same edge. At defaults a sustained burst fills the FIFO to exactly DEPTH.
- R10: At most one packet enters and one leaves per edge. `dst_valid` is 1 exactly when `occupancy` is nonzero, and a packet leaves on an edge where `dst_valid` and `drain_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Source offers a packet |
| src_data | input | W | Packet payload from the source |
| src_ready | output | 1 | Sender observes Go; a packet is taken when valid and ready |
| drain_en | input | 1 | Consumer removes the head packet this edge when one is present |
| dst_valid | output | 1 | FIFO holds at least one packet |
| dst_data | output | W | Oldest packet in the FIFO |
| occupancy | output | $clog2(DEPTH+1) | Packets stored in the FIFO |
| rx_stop | output | 1 | Backpressure bit at the receiver, 1 = Stop |
| overflow_err | output | 1 | Sticky error flag: an arrival found the FIFO full |

## Verification
A sustained burst with draining disabled drives occupancy through GO→STOP. It then shows that the packets in flight fill the FIFO to exactly its depth without an overflow. A drain-only phase afterwards isolates the STOP→GO transition and the return of `src_ready` one link delay later. Random segments then vary the source and drain rates independently. Rates near balance keep occupancy inside the hysteresis band and show that the bit holds there. Lopsided rates make the bit toggle repeatedly, which tests both delay pipelines, arrival order and the drain-hold rule against a cycle model kept in the bench.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
    typedef enum logic {
        FC_GO   = 1'b0,
        FC_STOP = 1'b1
    } fc_state_e;
endpackage

// File: rtl/lfc_delay_line.sv
// Fixed-latency register pipeline modelling a link wire of DELAY cycles.
module lfc_delay_line #(
    parameter int unsigned W     = 1,
    parameter int unsigned DELAY = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DELAY == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] stage [DELAY];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DELAY; i++) stage[i] <= RST_VAL;
                end else begin
                    stage[0] <= d;
                    for (int i = 1; i < DELAY; i++) stage[i] <= stage[i-1];
                end
            end
            assign q = stage[DELAY-1];
        end
    endgenerate
endmodule

// File: rtl/lfc_fifo.sv
// Receive queue: one push and one pop per edge, sticky overflow flag.
module lfc_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_next,
    output logic          empty,
    output logic          ovf
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_comb begin
        count_next = count;
        if (do_push && !do_pop) count_next = count + 1'b1;
        else if (do_pop && !do_push) count_next = count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            count <= count_next;
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            if (push && full && !do_pop) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/lfc_hyst_fsm.sv
// Two-threshold hysteresis on FIFO occupancy producing the Stop/Go bit.
module lfc_hyst_fsm
    import lfc_pkg::*;
#(
    parameter int unsigned CW      = 5,
    parameter int unsigned STOP_TH = 10,
    parameter int unsigned GO_TH   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ_next,
    output logic          stop_bit
);
    localparam logic [CW-1:0] STOP_V = CW'(STOP_TH);
    localparam logic [CW-1:0] GO_V   = CW'(GO_TH);

    fc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FC_GO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        stop_bit = 1'b0;
        unique case (state_q)
            FC_GO: begin
                stop_bit = 1'b0;
                if (occ_next >= STOP_V) state_d = FC_STOP;
            end
            FC_STOP: begin
                stop_bit = 1'b1;
                if (occ_next <= GO_V) state_d = FC_GO;
            end
        endcase
    end
endmodule

// File: rtl/lfc_sender.sv
// Sender port: launches a packet only while the observed bit reads Go.
module lfc_sender #(
    parameter int unsigned W = 8
) (
    input  logic         src_valid,
    input  logic [W-1:0] src_data,
    input  logic         stop_seen,
    output logic         src_ready,
    output logic         launch_valid,
    output logic [W-1:0] launch_data
);
    assign src_ready    = !stop_seen;
    assign launch_valid = src_valid && src_ready;
    assign launch_data  = src_data;
endmodule

// File: rtl/lfc_link.sv
module lfc_link #(
    parameter int unsigned W          = 8,
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned LINK_DELAY = 3,
    parameter int unsigned STOP_TH    = 10,
    parameter int unsigned GO_TH      = 4,
    localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_valid,
    input  logic [W-1:0]  src_data,
    output logic          src_ready,
    input  logic          drain_en,
    output logic          dst_valid,
    output logic [W-1:0]  dst_data,
    output logic [CW-1:0] occupancy,
    output logic          rx_stop,
    output logic          overflow_err
);
    generate
        if (STOP_TH + 2 * LINK_DELAY > DEPTH) begin : g_bad_headroom
            $error("lfc_link: STOP_TH leaves too little headroom for the link delay");
        end
        if (GO_TH >= STOP_TH) begin : g_bad_band
            $error("lfc_link: GO_TH must be below STOP_TH");
        end
    endgenerate

    logic         stop_seen, launch_valid;
    logic [W-1:0] launch_data;
    logic [W:0]   wire_in, wire_out;
    logic [CW-1:0] occ_next;
    logic          fifo_empty;

    lfc_sender #(.W(W)) u_tx (
        .src_valid   (src_valid),
        .src_data    (src_data),
        .stop_seen   (stop_seen),
        .src_ready   (src_ready),
        .launch_valid(launch_valid),
        .launch_data (launch_data)
    );

    assign wire_in = {launch_valid, launch_data};

    lfc_delay_line #(.W(W + 1), .DELAY(LINK_DELAY), .RST_VAL('0)) u_data_wire (
        .clk(clk), .rst_n(rst_n), .d(wire_in), .q(wire_out)
    );

    lfc_fifo #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wire_out[W]),
        .push_data (wire_out[W-1:0]),
        .pop       (drain_en),
        .head      (dst_data),
        .count     (occupancy),
        .count_next(occ_next),
        .empty     (fifo_empty),
        .ovf       (overflow_err)
    );

    lfc_hyst_fsm #(.CW(CW), .STOP_TH(STOP_TH), .GO_TH(GO_TH)) u_ctl (
        .clk(clk), .rst_n(rst_n), .occ_next(occ_next), .stop_bit(rx_stop)
    );

    lfc_delay_line #(.W(1), .DELAY(LINK_DELAY), .RST_VAL(1'b0)) u_ctl_wire (
        .clk(clk), .rst_n(rst_n), .d(rx_stop), .q(stop_seen)
    );

    assign dst_valid = !fifo_empty;
endmodule

// File: rtl/lfc_link_chk.sv
module lfc_link_chk #(
    parameter int unsigned CW      = 5,
    parameter int unsigned STOP_TH = 10,
    parameter int unsigned GO_TH   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          drain_en,
    input logic [CW-1:0] occupancy,
    input logic          rx_stop,
    input logic          overflow_err
);
    localparam logic [CW-1:0] STOP_V = CW'(STOP_TH);
    localparam logic [CW-1:0] GO_V   = CW'(GO_TH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !overflow_err); // R9
    AST_STOP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_stop) |-> occupancy >= STOP_V); // R5
    AST_STOP_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) occupancy >= STOP_V |-> rx_stop); // R5
    AST_GO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(rx_stop) |-> occupancy <= GO_V); // R6
    AST_GO_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n) occupancy <= GO_V |-> !rx_stop); // R6
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !drain_en |=> occupancy >= $past(occupancy)); // R8
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, occupancy} <= {1'b0, $past(occupancy)} + 1'b1) &&
        ({1'b0, occupancy} + 1'b1 >= {1'b0, $past(occupancy)})); // R10
endmodule

bind lfc_link lfc_link_chk #(.CW(CW), .STOP_TH(STOP_TH), .GO_TH(GO_TH)) u_chk (
    .clk(clk), .rst_n(rst_n), .drain_en(drain_en), .occupancy(occupancy),
    .rx_stop(rx_stop), .overflow_err(overflow_err)
);

// File: tb/lfc_link_test.sv
`timescale 1ns/100ps
module lfc_link_test;
    localparam int W = 8, DEPTH = 16, LD = 3, STOP_TH = 10, GO_TH = 4;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic src_valid = 1'b0, drain_en = 1'b0;
    logic [W-1:0] src_data = '0;
    logic src_ready, dst_valid, rx_stop, overflow_err;
    logic [W-1:0] dst_data;
    logic [CW-1:0] occupancy;

    lfc_link #(.W(W), .DEPTH(DEPTH), .LINK_DELAY(LD), .STOP_TH(STOP_TH), .GO_TH(GO_TH)) uut (.*);

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    // Bench model built from the requirements
    bit         m_pv [LD];
    logic [W-1:0] m_pd [LD];
    bit         m_ctl [LD];
    bit         m_stop;
    logic [W-1:0] m_q [$];
    int         prev_occ;
    bit         prev_drain;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit next_stop(input bit cur, input int occ);
        if (!cur && occ >= STOP_TH) return 1'b1;
        if (cur && occ <= GO_TH) return 1'b0;
        return cur;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < LD; i++) begin m_pv[i] = 0; m_pd[i] = '0; m_ctl[i] = 0; end
        m_stop = 0; m_q.delete(); prev_drain = 1; prev_occ = 0;
    endtask

    task automatic model_step(input bit v, input logic [W-1:0] d, input bit dr);
        bit take, arrive;
        take = v && !m_ctl[LD-1];                      // R2
        arrive = m_pv[LD-1];                           // R3
        if (dr && m_q.size() > 0) void'(m_q.pop_front());
        if (arrive && m_q.size() < DEPTH) m_q.push_back(m_pd[LD-1]);
        for (int i = LD - 1; i > 0; i--) begin
            m_pv[i] = m_pv[i-1]; m_pd[i] = m_pd[i-1]; m_ctl[i] = m_ctl[i-1];
        end
        m_pv[0] = take; m_pd[0] = d; m_ctl[0] = m_stop;  // R4: control wire carries old bit
        m_stop = next_stop(m_stop, m_q.size());
    endtask

    task automatic compare();
        chk(int'(occupancy) == m_q.size(), "R2 R3 occupancy", occupancy, m_q.size());
        chk(rx_stop == m_stop, "R5 R6 rx_stop", rx_stop, m_stop);
        chk(src_ready == !m_ctl[LD-1], "R4 src_ready", src_ready, !m_ctl[LD-1]);
        chk(dst_valid == (m_q.size() > 0), "R10 dst_valid", dst_valid, m_q.size() > 0);
        chk(overflow_err == 1'b0, "R9 overflow_err", overflow_err, 0);
        if (m_q.size() > 0) chk(dst_data == m_q[0], "R7 dst_data", dst_data, m_q[0]);
        if (!prev_drain) chk(int'(occupancy) >= prev_occ, "R8 drain hold", occupancy, prev_occ);
    endtask

    task automatic cycle(input bit v, input logic [W-1:0] d, input bit dr);
        @(negedge clk);
        compare();
        prev_occ = occupancy; prev_drain = dr;
        src_valid = v; src_data = d; drain_en = dr;
        model_step(v, d, dr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, run hung");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1f0c));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(rx_stop == 0 && src_ready == 1 && occupancy == 0 && dst_valid == 0 && overflow_err == 0,
            "R1 reset outputs", {rx_stop, src_ready, dst_valid, overflow_err}, 4'b0100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_stop == 0 && src_ready == 1 && occupancy == 0 && dst_valid == 0,
            "R1 after release", {rx_stop, src_ready, dst_valid}, 3'b010);

        // Burst with no draining: GO->STOP, then FIFO fills to exactly DEPTH (R9)
        for (int i = 0; i < 40; i++) cycle(1'b1, W'(i + 1), 1'b0);
        @(negedge clk);
        chk(int'(occupancy) == DEPTH, "R9 burst fills to depth", occupancy, DEPTH);
        chk(rx_stop == 1 && src_ready == 0, "R5 R2 stop held", {rx_stop, src_ready}, 2'b10);
        prev_drain = 1;

        // Drain only: STOP->GO at GO_TH, ready returns LD edges later
        for (int i = 0; i < 30; i++) cycle(1'b0, '0, 1'b1);

        // Offer while stopped then drain: exercised under random segments too
        for (int seg = 0; seg < 16; seg++) begin
            int pv, pd;
            pv = $urandom_range(100);
            pd = $urandom_range(100);
            if (seg == 3) begin pv = 100; pd = 0; end
            if (seg == 4) begin pv = 0; pd = 100; end
            if (seg == 7) begin pv = 60; pd = 60; end
            for (int i = 0; i < 250; i++)
                cycle($urandom_range(99) < pv, W'($urandom()), $urandom_range(99) < pd);
        end

        for (int i = 0; i < 40; i++) cycle(1'b0, '0, 1'b1);
        @(negedge clk);
        chk(occupancy == 0 && dst_valid == 0, "R10 drained empty", occupancy, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule